// File: doc/BRIEF.md
# B-Channel Sub-Rate Bit Mapper

This block places a slow synchronous user bit stream into the octets of a 64 kbps ISDN B channel and recovers it again. The channel carries one 8-bit octet in each 125 us slot. A one-cycle frame strobe marks the slot boundaries. An 8-bit mask written at run time selects the octet bit positions that carry user data. The same datapath therefore serves 8, 16, 32 and 56 kbps users: mask one, two, four or seven bits.

On the transmit side, user bits arrive on a ready/valid serial port during a slot. They are packed into an octet that goes out at the next strobe. Positions outside the mask are sent as ones. On the receive side, the octet present at a strobe has its masked bits pulled out. These bits are then offered one per cycle on a serial valid port. No framing is added or removed; the channel is transparent. The slot must last at least ten clock cycles.

Top module: `bchan_submap`

## Requirements
- R1: After reset, `tx_octet` is 0xFF, `rx_valid`, `tx_ready`, `tx_underrun` and `rx_overrun` are low, and the active mask is zero.
- R2: At the clock edge where `fsync` is high, `tx_octet` takes the octet assembled in the slot that just ended. The first accepted user bit goes to the highest set mask bit, the next to the next lower set bit, and so on. Every bit position whose mask bit is 0 is 1.
- R3: `tx_ready` is high exactly when `fsync` is low and fewer bits have been accepted in the current slot than the active mask has set bits.
- R4: If fewer user bits were accepted in a slot than the mask has set bits, the missing positions go out as 1. `tx_underrun` is then high for the one cycle after the strobe edge. It is never high otherwise.
- R5: The `rx_octet` value sampled at a strobe edge is delivered from the next cycle on. Delivery runs one bit per cycle on `rx_bit` with `rx_valid` high, from the highest set mask bit downward. There are as many cycles as the mask has set bits.
- R6: A delivered bit with `rx_ready` low is dropped without delay or retry, and `rx_overrun` is high in that same cycle.
- R7: A mask write is held until the next `fsync` edge and becomes active there. A write in the strobe cycle itself waits for the following strobe. Both directions use the mask that was active during the slot that a strobe closes.
- R8: With an active mask of zero, the transmitted octet is 0xFF, no receive bits are produced, `tx_ready` stays low and no underrun is flagged.
- R9: Masks with one, two, four and seven set bits carry 8, 16, 32 and 56 kbps streams with the mapping of R2 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | One-cycle strobe at each slot boundary |
| mask_we | input | 1 | Mask write enable |
| mask_wdata | input | 8 | New mask value |
| tx_valid | input | 1 | User transmit bit valid |
| tx_bit | input | 1 | User transmit bit |
| tx_ready | output | 1 | Block accepts a transmit bit |
| tx_octet | output | 8 | Octet toward the B channel |
| tx_underrun | output | 1 | Slot closed short of user bits |
| rx_octet | input | 8 | Octet from the B channel |
| rx_valid | output | 1 | Extracted receive bit valid |
| rx_bit | output | 1 | Extracted receive bit |
| rx_ready | input | 1 | User side accepts the receive bit |
| rx_overrun | output | 1 | Receive bit dropped |

## Verification
Some properties are checked on every cycle. The accepted count never exceeds the set bits of the active mask. The active mask changes only at a strobe edge. Every unmasked position of a new octet is 1. An underrun pulse follows only a strobe. A zero mask yields 0xFF and no receive traffic. Other behaviour shows up only in the bench's slot scenarios. These include the bit order within an octet and the filling of missing bits. They also include the one-slot delay of a mask write, including a write that lands on the strobe cycle, and the loss of bits when the user side is not ready.

// File: rtl/bchan_submap.sv
module bchan_submap #(
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  input  logic          mask_we,
  input  logic [OW-1:0] mask_wdata,
  input  logic          tx_valid,
  input  logic          tx_bit,
  output logic          tx_ready,
  output logic [OW-1:0] tx_octet,
  output logic          tx_underrun,
  input  logic [OW-1:0] rx_octet,
  output logic          rx_valid,
  output logic          rx_bit,
  input  logic          rx_ready,
  output logic          rx_overrun
);
  localparam int CW = $clog2(OW + 1);

  logic [OW-1:0] mask_pend, act_mask, tx_buf, rx_sh;
  logic [CW-1:0] tx_cnt, rx_left, need;

  function automatic logic [OW-1:0] pack_tx(input logic [OW-1:0] m, input logic [OW-1:0] b,
                                            input logic [CW-1:0] n);
    logic [OW-1:0] o;
    int j;
    o = '1;
    j = 0;
    for (int i = OW - 1; i >= 0; i--) begin
      if (m[i]) begin
        if (j < int'(n)) o[i] = b[OW-1-j];
        j++;
      end
    end
    return o;
  endfunction

  function automatic logic [OW-1:0] squeeze(input logic [OW-1:0] m, input logic [OW-1:0] d);
    logic [OW-1:0] o;
    int j;
    o = '0;
    j = 0;
    for (int i = OW - 1; i >= 0; i--) begin
      if (m[i]) begin
        o[OW-1-j] = d[i];
        j++;
      end
    end
    return o;
  endfunction

  assign need       = CW'($countones(act_mask));
  assign tx_ready   = !fsync && (tx_cnt < need);
  assign rx_valid   = (rx_left != '0);
  assign rx_bit     = rx_sh[OW-1];
  assign rx_overrun = rx_valid && !rx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_pend   <= '0;
      act_mask    <= '0;
      tx_buf      <= '0;
      tx_cnt      <= '0;
      tx_octet    <= '1;
      tx_underrun <= 1'b0;
      rx_sh       <= '0;
      rx_left     <= '0;
    end else begin
      if (mask_we) mask_pend <= mask_wdata;
      if (fsync) begin
        act_mask    <= mask_pend;
        tx_octet    <= pack_tx(act_mask, tx_buf, tx_cnt);
        tx_underrun <= (tx_cnt < need);
        tx_cnt      <= '0;
        rx_sh       <= squeeze(act_mask, rx_octet);
        rx_left     <= need;
      end else begin
        tx_underrun <= 1'b0;
        if (tx_valid && tx_ready) begin
          tx_buf[OW-1-int'(tx_cnt)] <= tx_bit;
          tx_cnt <= tx_cnt + 1'b1;
        end
        if (rx_valid) begin
          rx_sh   <= {rx_sh[OW-2:0], 1'b0};
          rx_left <= rx_left - 1'b1;
        end
      end
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tx_cnt) <= $countones(act_mask));

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fsync |=> $stable(act_mask));

  p_unmasked_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> ((tx_octet | $past(act_mask)) == '1));

  p_underrun_after_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |-> $past(fsync));

  p_zero_mask_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && act_mask == '0) |=> (tx_octet == '1 && !rx_valid && !tx_underrun));
endmodule

// File: tb/tb_bchan_submap.sv
`timescale 1ns/1ps
module tb_bchan_submap;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0, mask_we = 1'b0, tx_valid = 1'b0, tx_bit = 1'b0, rx_ready = 1'b0;
  logic [7:0] mask_wdata = '0, rx_octet = '0;
  logic tx_ready, tx_underrun, rx_valid, rx_bit, rx_overrun;
  logic [7:0] tx_octet;

  int checks = 0, errors = 0;
  logic [7:0] m_act = '0, m_pend = '0, exp_tx = 8'hFF, exp_rx = '0;
  logic exp_under = 1'b0;
  logic acc [8];
  int acc_n = 0, exp_rx_n = 0, rx_idx = 0;
  bit started = 0;

  always #5 clk = ~clk;

  bchan_submap dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ready(tx_ready), .tx_octet(tx_octet),
    .tx_underrun(tx_underrun), .rx_octet(rx_octet), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .rx_ready(rx_ready), .rx_overrun(rx_overrun)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_tx(input logic [7:0] m);
    logic [7:0] o = 8'hFF;
    int k = 0;
    for (int i = 7; i >= 0; i--)
      if (m[i]) begin
        o[i] = (k < acc_n) ? acc[k] : 1'b1;
        k++;
      end
    return o;
  endfunction

  function automatic logic [7:0] model_rx(input logic [7:0] m, input logic [7:0] d);
    logic [7:0] o = '0;
    int k = 0;
    for (int i = 7; i >= 0; i--)
      if (m[i]) begin
        o[7-k] = d[i];
        k++;
      end
    return o;
  endfunction

  task automatic slot(input int len, input int pv, input int pr, input int wr_at,
                      input logic [7:0] wr_val, input logic [7:0] rxo, input string tag);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      if (c == 1) begin
        chk(tx_octet == exp_tx, tag, tx_octet, exp_tx);
        chk(tx_underrun == exp_under, "R4 underrun flag", {7'b0, tx_underrun}, {7'b0, exp_under});
      end
      fsync      = (c == 0);
      tx_valid   = (c != 0) && (($urandom % 100) < pv);
      tx_bit     = $urandom % 2;
      rx_ready   = ($urandom % 100) < pr;
      mask_we    = (c == wr_at);
      mask_wdata = wr_val;
      if (c == 0) rx_octet = rxo;
      #1;
      if (rx_valid) begin
        if (rx_idx < exp_rx_n) begin
          if (rx_ready) chk(rx_bit == exp_rx[7-rx_idx], "R5 rx bit", {7'b0, rx_bit}, {7'b0, exp_rx[7-rx_idx]});
          chk(rx_overrun == !rx_ready, "R6 overrun", {7'b0, rx_overrun}, {7'b0, !rx_ready});
        end else chk(1'b0, "R5 extra rx bit", 8'd1, 8'd0);
        rx_idx++;
      end
      chk(tx_ready == (c != 0 && acc_n < $countones(m_act)), "R3 tx_ready",
          {7'b0, tx_ready}, {7'b0, (c != 0 && acc_n < $countones(m_act))});
      if (tx_valid && tx_ready && acc_n < 8) begin
        acc[acc_n] = tx_bit;
        acc_n++;
      end
      if (c == 0) begin
        if (started) chk(rx_idx == exp_rx_n, "R5 rx count", 8'(rx_idx), 8'(exp_rx_n));
        exp_tx    = model_tx(m_act);
        exp_under = ($countones(m_act) != 0) && (acc_n < $countones(m_act));
        exp_rx    = model_rx(m_act, rxo);
        exp_rx_n  = $countones(m_act);
        rx_idx    = 0;
        m_act     = m_pend;
        acc_n     = 0;
        started   = 1;
      end
      if (mask_we) m_pend = wr_val;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D0C));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    chk(tx_octet == 8'hFF, "R1 tx_octet", tx_octet, 8'hFF);
    chk(!rx_valid && !tx_ready && !tx_underrun && !rx_overrun, "R1 flags",
        {4'b0, rx_valid, tx_ready, tx_underrun, rx_overrun}, 8'h00);
    // R8: channel disabled, then a mid-slot write
    slot(12, 80, 80, -1, 8'h00, 8'hA5, "R8 zero mask");
    slot(12, 80, 80, 3, 8'hFE, 8'h3C, "R8 zero mask");
    chk(tx_octet == 8'hFF && !rx_valid, "R8 idle octet", tx_octet, 8'hFF);
    // R9 56 kbps, full supply
    slot(12, 100, 100, -1, 8'h00, 8'h5A, "R9 seven-bit mask");
    // R4 starve the transmit side
    slot(12, 0, 100, -1, 8'h00, 8'hC3, "R9 seven-bit mask");
    slot(12, 100, 0, -1, 8'h00, 8'h96, "R4 underrun fill");
    // R6 nothing accepted on receive; R7 write on the strobe cycle
    slot(12, 100, 100, 0, 8'h80, 8'h69, "R6 after drop");
    slot(12, 100, 100, -1, 8'h00, 8'hF0, "R7 write on strobe");
    slot(12, 100, 100, 5, 8'hC0, 8'h0F, "R7 write on strobe");
    slot(12, 100, 100, 5, 8'hF0, 8'hAA, "R9 one-bit mask");
    slot(12, 100, 100, -1, 8'h00, 8'h55, "R9 two-bit mask");
    slot(12, 100, 100, -1, 8'h00, 8'hE7, "R9 four-bit mask");
    for (int s = 0; s < 400; s++) begin
      logic [7:0] nm;
      case ($urandom % 8)
        0: nm = 8'h80; 1: nm = 8'hC0; 2: nm = 8'hF0; 3: nm = 8'hFE;
        4: nm = 8'h00; 5: nm = 8'h0F; default: nm = 8'($urandom);
      endcase
      slot(10 + ($urandom % 8), 30 + ($urandom % 71), 40 + ($urandom % 61),
           (($urandom % 3) == 0) ? int'($urandom % 10) : -1, nm, 8'($urandom), "R2 random mapping");
    end
    slot(12, 0, 100, -1, 8'h00, 8'h00, "R2 final octet");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule